// File: doc/BRIEF.md
# Unrolled Binary-Field Matrix Hash Core

This core computes a provably-secure style hash. The hash state is a row vector of two elements (a, b) of GF(2^127), with the field reduced by X^127 + X + 1. Each message bit selects one of two fixed 2x2 matrices, and the state is multiplied on the right by that matrix. The core applies up to `SPAN` such bit steps per clock through a chain of identical combinational stages. When the remaining bit count is not a multiple of the span, the stages beyond the valid bits are bypassed.

A hash begins with a `start` pulse. That pulse samples a 254-bit key, which serves as the initial state, and the message length in bits. Message words of 32 bits then arrive over a valid/ready handshake and are consumed most significant bit first. Bits past the stated length in the last word are dropped.

After the last message bit, the core enters a closing phase. The current state, XORed with a fixed 254-bit constant (by default the binary expansion of pi), is hashed as 254 further message bits: the a half first, then the b half. The final state a||b is the digest, and it comes out with a one-cycle `done` pulse. An all-zero key is refused: the core raises an error flag and does not start.

Top module: `gfmat_hash`

## Requirements
- R1: A message bit of 0 maps the state (a, b) to (aX + b, a), with addition being bitwise XOR.
- R2: A message bit of 1 maps the state (a, b) to (aX + b, aX + a + b).
- R3: Multiplying by X shifts left by one bit. If the bit leaving position 126 is 1, bits 1 and 0 of the result are inverted.
- R4: A `start` with an all-zero key sets `keyError` on the next edge, leaves `busy` low and produces no `done`. `keyError` stays set until the next accepted `start` clears it.
- R5: Message bits are taken MSB-first, word after word. Exactly `msgLen` bits are hashed, and the bits past the length in the last word have no effect on the digest.
- R6: After the message, 254 more bits equal to {a, b} XOR the constant are hashed, MSB-first, the a part before the b part. This also applies to a zero-length message.
- R7: `done` is high for exactly one cycle. In that cycle `digest` holds {a, b}, with a in bits 253:127.
- R8: Each clock applies up to `SPAN` bits. A zero-length message raises `done` exactly 2 + ceil(254/SPAN) rising edges after the edge that samples `start` (53 for `SPAN` = 5). Message lengths of `SPAN`-1 and `SPAN` bits hash correctly.
- R9: While `busy` is high, `start` and `keyIn` are ignored.
- R10: A word transfers only on an edge where both `wordValid` and `wordReady` are high. Gaps in `wordValid` do not change the digest.
- R11: After reset, `busy`, `done`, `keyError` and `wordReady` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a hash; sampled only while idle |
| keyIn | input | 254 | Initial state {a0, b0}; must not be zero |
| msgLen | input | LEN_W | Message length in bits |
| wordData | input | WORD_W | Message word, first bit in the MSB |
| wordValid | input | 1 | wordData holds a word |
| wordReady | output | 1 | Core accepts a word on this edge |
| busy | output | 1 | A hash is in progress |
| done | output | 1 | One-cycle pulse: digest is final |
| keyError | output | 1 | Last start was refused for a zero key |
| digest | output | 254 | Final state {a, b} |

## Verification
`keyError` is due on the first edge after `start`, so the bench reads it at the following falling edge. Digests have no fixed delay for messages that carry data, because the handshake sets the pace. A monitor therefore samples at every falling edge, and on each `done` it pops the value a bit-serial reference model computed when the job was issued.

For the zero-length message the delay is fixed. The monitor counts rising edges from the sampling edge of `start` and expects `done` after exactly 53. Handshake inputs are changed on falling edges, and `wordReady` is read mid-cycle, so the bench knows which words the next edge takes.

// File: rtl/gfmat_hash_pkg.sv
package gfmat_hash_pkg;
  localparam int FIELD_N = 127;
  localparam int STATE_W = 2 * FIELD_N;
  localparam logic [FIELD_N-1:0] POLY_LOW = 127'h3;
  localparam int SPAN_DEF = 5;
  localparam int WORD_DEF = 32;
  localparam int LEN_DEF = 16;
  localparam int STEP_CW = 8;
  localparam logic [255:0] PI_WIDE =
    256'h3243F6A8885A308D313198A2E03707344A4093822299F31D0082EFA98EC4E6C8;
  localparam logic [STATE_W-1:0] PI_DEF = PI_WIDE[STATE_W-1:0];

  typedef logic [FIELD_N-1:0] elem_t;

  typedef struct packed {
    logic loadKey;
    logic loadFin;
    logic stepMsg;
    logic stepFin;
    logic takeWord;
    logic [STEP_CW-1:0] stepCnt;
    logic [STEP_CW-1:0] keepCnt;
  } strobe_t;

  function automatic elem_t mul_x(input elem_t v);
    return {v[FIELD_N-2:0], 1'b0} ^ (v[FIELD_N-1] ? POLY_LOW : '0);
  endfunction

  function automatic logic [STATE_W-1:0] step_ab(input elem_t a, input elem_t b, input logic bitV);
    elem_t ax;
    ax = mul_x(a);
    return bitV ? {ax ^ b, ax ^ a ^ b} : {ax ^ b, a};
  endfunction
endpackage

// File: rtl/gfmat_hash_dp.sv
module gfmat_hash_dp
  import gfmat_hash_pkg::*;
#(
  parameter int SPAN = SPAN_DEF,
  parameter int WORD_W = WORD_DEF,
  parameter logic [STATE_W-1:0] PI_CONST = PI_DEF
) (
  input  logic               clk,
  input  logic               rst_n,
  input  strobe_t            ctl,
  input  logic [STATE_W-1:0] keyIn,
  input  logic [WORD_W-1:0]  wordData,
  output logic [STATE_W-1:0] stateAB
);
  localparam int BUF_W = WORD_W + SPAN;

  elem_t aReg, bReg;
  logic [BUF_W-1:0] bitBuf;
  logic [STATE_W-1:0] finBits;
  logic [SPAN-1:0] srcBits;
  logic [BUF_W-1:0] wordPlaced;
  elem_t chainA [SPAN+1];
  elem_t chainB [SPAN+1];

  assign srcBits = ctl.stepFin ? finBits[STATE_W-1 -: SPAN] : bitBuf[BUF_W-1 -: SPAN];
  assign chainA[0] = aReg;
  assign chainB[0] = bReg;

  for (genvar i = 0; i < SPAN; i++) begin : g_stage
    logic [STATE_W-1:0] nxt;
    logic live;
    assign nxt = step_ab(chainA[i], chainB[i], srcBits[SPAN-1-i]);
    assign live = (STEP_CW'(i) < ctl.stepCnt);
    assign chainA[i+1] = live ? nxt[STATE_W-1:FIELD_N] : chainA[i];
    assign chainB[i+1] = live ? nxt[FIELD_N-1:0] : chainB[i];
  end

  assign wordPlaced = ctl.takeWord
    ? (BUF_W'(wordData) << (BUF_W - WORD_W - int'(ctl.keepCnt))) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      aReg <= '0;
      bReg <= '0;
      bitBuf <= '0;
      finBits <= '0;
    end else begin
      if (ctl.loadKey) begin
        aReg <= keyIn[STATE_W-1:FIELD_N];
        bReg <= keyIn[FIELD_N-1:0];
        bitBuf <= '0;
      end else if (ctl.stepMsg || ctl.stepFin) begin
        aReg <= chainA[SPAN];
        bReg <= chainB[SPAN];
      end
      if (ctl.stepMsg) bitBuf <= (bitBuf << ctl.stepCnt) | wordPlaced;
      if (ctl.loadFin) finBits <= {aReg, bReg} ^ PI_CONST;
      else if (ctl.stepFin) finBits <= finBits << ctl.stepCnt;
    end
  end

  assign stateAB = {aReg, bReg};

  // R4: matrices are invertible, so a nonzero key never decays to zero
  assert_state_live_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.stepMsg || ctl.stepFin) |-> (aReg != '0 || bReg != '0));
  assert_strobe_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ctl.loadKey, ctl.loadFin, ctl.stepMsg, ctl.stepFin}));
  assert_step_span_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.stepCnt <= STEP_CW'(SPAN));
endmodule

// File: rtl/gfmat_hash_ctrl.sv
module gfmat_hash_ctrl
  import gfmat_hash_pkg::*;
#(
  parameter int SPAN = SPAN_DEF,
  parameter int WORD_W = WORD_DEF,
  parameter int LEN_W = LEN_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             keyZero,
  input  logic [LEN_W-1:0] msgLen,
  input  logic             wordValid,
  output logic             wordReady,
  output logic             busy,
  output logic             done,
  output logic             keyError,
  output strobe_t          ctl
);
  localparam int BUF_W = WORD_W + SPAN;
  localparam int BC_W = $clog2(BUF_W + 1);
  localparam int FIN_TOTAL = STATE_W;
  localparam int FR_W = $clog2(FIN_TOTAL + 1);

  typedef enum logic [1:0] {ST_IDLE, ST_MSG, ST_FIN} phase_t;

  phase_t phase;
  logic [LEN_W-1:0] remBits, fetchRem;
  logic [BC_W-1:0] bufCnt;
  logic [FR_W-1:0] finRem;
  logic doneReg, errReg, takeWord;
  int kMsg, kFin, keepNum;

  always_comb begin
    kMsg = int'(bufCnt);
    if (int'(remBits) < kMsg) kMsg = int'(remBits);
    if (kMsg > SPAN) kMsg = SPAN;
    kFin = (int'(finRem) < SPAN) ? int'(finRem) : SPAN;
    keepNum = int'(bufCnt) - kMsg;
  end

  assign wordReady = (phase == ST_MSG) && (fetchRem != '0) && (keepNum <= SPAN);
  assign takeWord = wordReady && wordValid;

  always_comb begin
    ctl = '0;
    ctl.loadKey = (phase == ST_IDLE) && start && !keyZero;
    ctl.loadFin = (phase == ST_MSG) && (remBits == '0);
    ctl.stepMsg = (phase == ST_MSG) && (remBits != '0);
    ctl.stepFin = (phase == ST_FIN);
    ctl.takeWord = takeWord;
    ctl.keepCnt = STEP_CW'(keepNum);
    if (phase == ST_FIN) ctl.stepCnt = STEP_CW'(kFin);
    else if (ctl.stepMsg) ctl.stepCnt = STEP_CW'(kMsg);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= ST_IDLE;
      remBits <= '0;
      fetchRem <= '0;
      bufCnt <= '0;
      finRem <= '0;
      doneReg <= 1'b0;
      errReg <= 1'b0;
    end else begin
      doneReg <= 1'b0;
      unique case (phase)
        ST_IDLE: begin
          if (start) begin
            errReg <= keyZero;
            if (!keyZero) begin
              remBits <= msgLen;
              fetchRem <= msgLen;
              bufCnt <= '0;
              phase <= ST_MSG;
            end
          end
        end
        ST_MSG: begin
          if (remBits == '0) begin
            finRem <= FR_W'(FIN_TOTAL);
            phase <= ST_FIN;
          end else begin
            remBits <= remBits - LEN_W'(kMsg);
            bufCnt <= BC_W'(keepNum + (takeWord ? WORD_W : 0));
            if (takeWord)
              fetchRem <= (int'(fetchRem) > WORD_W) ? fetchRem - LEN_W'(WORD_W) : '0;
          end
        end
        ST_FIN: begin
          finRem <= finRem - FR_W'(kFin);
          if (int'(finRem) == kFin) begin
            doneReg <= 1'b1;
            phase <= ST_IDLE;
          end
        end
        default: phase <= ST_IDLE;
      endcase
    end
  end

  assign busy = (phase != ST_IDLE);
  assign done = doneReg;
  assign keyError = errReg;

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    doneReg |=> !doneReg);
  assert_zero_key_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == ST_IDLE && start && keyZero) |=> (errReg && phase == ST_IDLE));
  assert_done_after_fin_R6: assert property (@(posedge clk) disable iff (!rst_n)
    doneReg |-> $past(phase == ST_FIN));
  assert_buf_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    int'(bufCnt) <= BUF_W);
endmodule

// File: rtl/gfmat_hash.sv
module gfmat_hash
  import gfmat_hash_pkg::*;
#(
  parameter int SPAN = SPAN_DEF,
  parameter int WORD_W = WORD_DEF,
  parameter int LEN_W = LEN_DEF,
  parameter logic [STATE_W-1:0] PI_CONST = PI_DEF
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [STATE_W-1:0] keyIn,
  input  logic [LEN_W-1:0]   msgLen,
  input  logic [WORD_W-1:0]  wordData,
  input  logic               wordValid,
  output logic               wordReady,
  output logic               busy,
  output logic               done,
  output logic               keyError,
  output logic [STATE_W-1:0] digest
);
  strobe_t ctl;
  logic keyZero;

  assign keyZero = (keyIn == '0);

  gfmat_hash_ctrl #(.SPAN(SPAN), .WORD_W(WORD_W), .LEN_W(LEN_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .keyZero(keyZero), .msgLen(msgLen),
    .wordValid(wordValid), .wordReady(wordReady), .busy(busy), .done(done),
    .keyError(keyError), .ctl(ctl));

  gfmat_hash_dp #(.SPAN(SPAN), .WORD_W(WORD_W), .PI_CONST(PI_CONST)) u_dp (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .keyIn(keyIn), .wordData(wordData),
    .stateAB(digest));
endmodule

// File: tb/gfmat_hash_bench.sv
`timescale 1ns/1ps
module gfmat_hash_bench;
  localparam logic [255:0] TB_PI_WIDE =
    256'h3243F6A8885A308D313198A2E03707344A4093822299F31D0082EFA98EC4E6C8;
  localparam logic [253:0] TB_PI = TB_PI_WIDE[253:0];
  localparam logic [253:0] KEY_A = {127'h4D2C6DFC5AC42AEED38CA2D2D7A8E4F1, 127'h1B873593CC9E2D51E6546B6413B1A3F0};
  localparam logic [253:0] KEY_B = {127'h7FFFFFFFFFFFFFFFFFFFFFFFFFFFFFFF, 127'h1};

  logic clk = 0, rst_n = 0, start = 0, wordValid = 0;
  logic [253:0] keyIn = '0;
  logic [15:0] msgLen = '0;
  logic [31:0] wordData = '0;
  logic wordReady, busy, done, keyError;
  logic [253:0] digest;

  int checks = 0, failures = 0, cyc = 0, startCyc = 0, lastLat = 0;
  bit prevDone = 0;
  logic [253:0] expQ[$];
  string tagQ[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  gfmat_hash #(.PI_CONST(TB_PI)) u_gfmat_hash (
    .clk(clk), .rst_n(rst_n), .start(start), .keyIn(keyIn), .msgLen(msgLen),
    .wordData(wordData), .wordValid(wordValid), .wordReady(wordReady), .busy(busy),
    .done(done), .keyError(keyError), .digest(digest));

  task automatic check(input bit ok, input string req, input logic [253:0] act, input logic [253:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [126:0] refMulX(input logic [126:0] v);
    return {v[125:0], 1'b0} ^ (v[126] ? 127'h3 : 127'h0);  // R3
  endfunction

  function automatic logic [253:0] refStep(input logic [253:0] ab, input logic bitV);
    logic [126:0] a, b, ax;
    a = ab[253:127];
    b = ab[126:0];
    ax = refMulX(a);
    if (bitV) return {ax ^ b, ax ^ a ^ b};  // R2
    return {ax ^ b, a};                    // R1
  endfunction

  // monitor: compare each digest against the queued reference value
  always @(negedge clk) begin
    if (rst_n) begin
      if (done) begin
        check(!prevDone, "R7 done longer than one cycle", 254'(prevDone), 254'(0));
        if (expQ.size() == 0) begin
          check(1'b0, "R4 unexpected done", 254'(1), 254'(0));
        end else begin
          logic [253:0] e;
          string t;
          e = expQ.pop_front();
          t = tagQ.pop_front();
          check(digest == e, t, digest, e);
          lastLat = cyc - startCyc;
        end
      end
      prevDone = done;
    end
  end

  task automatic runHash(input int len, input logic [253:0] key, input int fill,
                         input bit flipPad, input int stallEvery, input bit poke, input string tag);
    logic [31:0] words[];
    logic [253:0] ab, t;
    int nW, idx, gap;
    bit rdy;
    nW = (len + 31) / 32;
    words = new[nW];
    for (int i = 0; i < nW; i++) begin
      if (fill == 0) words[i] = '0;
      else if (fill == 1) words[i] = '1;
      else words[i] = ((32'(i) + 32'(fill)) * 32'h9E3779B9) ^ 32'h5A5A0F0F;
    end
    if (flipPad)
      for (int j = len; j < nW * 32; j++) words[j/32][31-(j%32)] = ~words[j/32][31-(j%32)];
    ab = key;
    for (int j = 0; j < len; j++) ab = refStep(ab, words[j/32][31-(j%32)]);  // R5 MSB-first
    t = ab ^ TB_PI;
    for (int j = 253; j >= 0; j--) ab = refStep(ab, t[j]);  // R6 a part then b part
    expQ.push_back(ab);
    tagQ.push_back(tag);

    @(negedge clk);
    start = 1; keyIn = key; msgLen = 16'(len); startCyc = cyc;
    @(negedge clk);
    start = 0;
    check(keyError == 0, "R4 accepted start clears keyError", 254'(keyError), 254'(0));
    if (poke) begin
      start = 1; keyIn = '0;
      @(negedge clk);
      start = 0;
      check(keyError == 0 && busy == 1, "R9 start while busy ignored", 254'({keyError, busy}), 254'(1));
    end
    idx = 0; gap = 0;
    while (idx < nW) begin
      if (stallEvery > 0 && gap == stallEvery) begin
        wordValid = 0; gap = 0;
        @(negedge clk);
      end else begin
        wordValid = 1; wordData = words[idx];
        #1 rdy = wordReady;
        @(negedge clk);
        if (rdy) begin idx++; gap++; end
      end
    end
    wordValid = 0; wordData = '0;
    while (expQ.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(busy == 0 && done == 0 && keyError == 0 && wordReady == 0, "R11 reset state",
          254'({busy, done, keyError, wordReady}), 254'(0));

    // R4: zero key refused
    start = 1; keyIn = '0; msgLen = 16'd8;
    @(negedge clk);
    start = 0;
    check(keyError == 1, "R4 keyError after zero key", 254'(keyError), 254'(1));
    check(busy == 0, "R4 no run on zero key", 254'(busy), 254'(0));
    repeat (60) @(negedge clk);
    check(keyError == 1 && busy == 0, "R4 keyError held, idle", 254'({keyError, busy}), 254'(2));

    runHash(0, KEY_A, 2, 0, 0, 0, "R6 zero-length digest");
    check(lastLat == 53, "R8 zero-length latency", 254'(lastLat), 254'(53));
    runHash(1, KEY_A, 0, 0, 0, 0, "R1 single zero bit");
    runHash(1, KEY_A, 1, 0, 0, 0, "R2 single one bit");
    runHash(4, KEY_A, 7, 0, 0, 0, "R8 length SPAN-1");
    runHash(5, KEY_A, 9, 0, 0, 0, "R8 length SPAN");
    runHash(45, KEY_A, 11, 0, 0, 0, "R5 partial last word");
    runHash(45, KEY_A, 11, 1, 0, 0, "R5 padding bits ignored");
    runHash(300, KEY_A, 13, 0, 2, 1, "R10 valid gaps");
    runHash(300, KEY_A, 13, 0, 0, 0, "R10 no gaps");
    runHash(600, KEY_B, 1, 0, 0, 0, "R3 reduction with top bit set");
    runHash(97, KEY_B, 17, 0, 1, 0, "R7 digest layout");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule